// File: doc/BRIEF.md
# Device Sleep Timing Monitor

This block watches the slow, externally driven device-sleep request line of a serial storage link and checks it against events on the link. The line is pulled up through a weak resistor, so it rises slowly and may cross the logic threshold several times during one transition. The monitor first passes it through a two-stage synchronizer. It then applies a digital debounce that accepts a new level only after the level has held for a programmable number of consecutive cycles.

The monitor measures each accepted sleep interval. It also measures the latency from the accepted release of the line to the device's out-of-band wake event. It flags three kinds of violation in separate sticky bits:

- The line was held for less than the programmed minimum.
- The wake event came later than the programmed limit, or did not come at all.
- The line was raised while the link was not yet in a power-management state.

A clear input resets the flags. Both measured durations saturate at the all-ones value of their counters and stay readable after each event. Typical limits correspond to 10 ms of hold time and 20 ms of detection time, converted to clock cycles by software.

Top module: `sleep_timing_monitor`

## Requirements
- R1: `sleep_filt` takes a new level only after the synchronized input (two flops) has differed from it for `db_cyc` consecutive cycles. From reset, a level held steady on `sleep_raw` appears on `sleep_filt` 2 + `db_cyc` clock edges after it is applied. Pulses or bounces shorter than `db_cyc` cycles are rejected. A `db_cyc` of 0 acts as 1.
- R2: When `sleep_filt` falls, `width_valid` pulses for one cycle. In the same cycle, `assert_width` takes the number of cycles `sleep_filt` was high.
- R3: `err_short` is set when a measured width is smaller than `min_assert_cyc`. A width equal to the minimum is legal.
- R4: After `sleep_filt` falls, an `oob_evt` pulse seen at the k-th following clock edge loads `wake_latency` with k and pulses `latency_valid`.
- R5: `err_late` is set when the wake event arrives with k greater than `max_detect_cyc`. It is also set when no event has arrived by edge `max_detect_cyc` + 1, which ends the wait. k equal to the limit is legal.
- R6: `err_nopm` is set when `sleep_filt` rises while `link_pm` is low.
- R7: When `sleep_filt` rises again while a wake event is still awaited, the wait is cancelled. No error is raised and `wake_latency` is left unchanged.
- R8: The three error flags stay set until `err_clr` is high for one cycle. A new violation in the same cycle as the clear wins.
- R9: `assert_width` and `wake_latency` saturate at 2^CNT_W - 1.
- R10: An `oob_evt` while no wake event is awaited changes neither `wake_latency`, `latency_valid` nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_raw | input | 1 | Unsynchronized sleep request line |
| link_pm | input | 1 | High while the link is in a power-management state |
| oob_evt | input | 1 | One-cycle pulse for each detected out-of-band wake event |
| db_cyc | input | DB_W | Debounce hold count in cycles |
| min_assert_cyc | input | CNT_W | Minimum legal sleep width in cycles |
| max_detect_cyc | input | CNT_W | Maximum legal wake latency in cycles |
| err_clr | input | 1 | Clears the sticky error flags |
| sleep_filt | output | 1 | Debounced sleep level |
| err_short | output | 1 | Sticky: sleep width below minimum |
| err_late | output | 1 | Sticky: wake event late or missing |
| err_nopm | output | 1 | Sticky: sleep raised outside power-management state |
| assert_width | output | CNT_W | Last measured sleep width |
| width_valid | output | 1 | Pulse when `assert_width` updates |
| wake_latency | output | CNT_W | Last measured wake latency |
| latency_valid | output | 1 | Pulse when `wake_latency` updates |

## Verification
The hardest situation to reach is a cancelled wake wait. The line must be released, the release accepted through the debounce, and the line raised again and accepted before the detection limit expires, with no wake event in between. The stimulus waits for the debounced output to fall and re-raises the line a few cycles later. It then holds the line high well beyond the limit, so that a missed cancellation would show up as a late error. Bounced rising edges are driven as single-cycle toggles ahead of a steady level, and the bench counts `width_valid` pulses to show that only one interval was accepted.

// File: rtl/sleep_timing_monitor.sv
module sleep_timing_monitor #(
  parameter int CNT_W = 32,
  parameter int DB_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_raw,
  input  logic             link_pm,
  input  logic             oob_evt,
  input  logic [DB_W-1:0]  db_cyc,
  input  logic [CNT_W-1:0] min_assert_cyc,
  input  logic [CNT_W-1:0] max_detect_cyc,
  input  logic             err_clr,
  output logic             sleep_filt,
  output logic             err_short,
  output logic             err_late,
  output logic             err_nopm,
  output logic [CNT_W-1:0] assert_width,
  output logic             width_valid,
  output logic [CNT_W-1:0] wake_latency,
  output logic             latency_valid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       sync_q;
  logic [DB_W-1:0]  db_cnt;
  logic [CNT_W-1:0] w_cnt;
  logic [CNT_W-1:0] l_cnt;
  logic             pending;

  wire            differ   = sync_q[1] ^ sleep_filt;
  wire [DB_W:0]   db_next  = {1'b0, db_cnt} + (DB_W+1)'(1);
  wire            accept   = differ && (db_next >= {1'b0, db_cyc});
  wire            rise_acc = accept && !sleep_filt;
  wire            fall_acc = accept && sleep_filt;

  wire [CNT_W-1:0] w_inc   = (w_cnt == CNT_MAX) ? w_cnt : w_cnt + 1'b1;
  wire [CNT_W-1:0] l_inc   = (l_cnt == CNT_MAX) ? l_cnt : l_cnt + 1'b1;
  wire             waiting = pending && !rise_acc;
  wire             lat_over = l_inc > max_detect_cyc;

  wire short_set = fall_acc && (w_inc < min_assert_cyc);
  wire late_set  = waiting && lat_over;
  wire nopm_set  = rise_acc && !link_pm;

  // input synchronizer and debounce
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      db_cnt     <= '0;
      sleep_filt <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], sleep_raw};
      if (!differ || accept) db_cnt <= '0;
      else                   db_cnt <= db_next[DB_W-1:0];
      if (accept) sleep_filt <= sync_q[1];
    end
  end

  // sleep width measurement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_cnt        <= '0;
      assert_width <= '0;
      width_valid  <= 1'b0;
    end else begin
      width_valid <= fall_acc;
      if (rise_acc)                    w_cnt <= '0;
      else if (sleep_filt && !fall_acc) w_cnt <= w_inc;
      if (fall_acc) assert_width <= w_inc;
    end
  end

  // wake latency measurement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending       <= 1'b0;
      l_cnt         <= '0;
      wake_latency  <= '0;
      latency_valid <= 1'b0;
    end else begin
      latency_valid <= 1'b0;
      if (rise_acc) begin
        pending <= 1'b0;
      end else if (fall_acc) begin
        pending <= 1'b1;
        l_cnt   <= '0;
      end else if (pending) begin
        if (oob_evt) begin
          pending       <= 1'b0;
          wake_latency  <= l_inc;
          latency_valid <= 1'b1;
        end else if (lat_over) begin
          pending <= 1'b0;
        end else begin
          l_cnt <= l_inc;
        end
      end
    end
  end

  // sticky flags, a new violation beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_short <= 1'b0;
      err_late  <= 1'b0;
      err_nopm  <= 1'b0;
    end else begin
      err_short <= short_set | (err_short & ~err_clr);
      err_late  <= late_set  | (err_late  & ~err_clr);
      err_nopm  <= nopm_set  | (err_nopm  & ~err_clr);
    end
  end

endmodule

module sleep_timing_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_raw,
  input logic link_pm,
  input logic oob_evt,
  input logic err_clr,
  input logic sleep_filt,
  input logic err_short,
  input logic err_late,
  input logic err_nopm,
  input logic width_valid,
  input logic latency_valid
);

  // R1
  filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_filt) |-> $past(sleep_raw, 3));

  // R1
  filt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_filt) |-> !$past(sleep_raw, 3));

  // R2
  width_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    width_valid |-> (!sleep_filt && $past(sleep_filt)));

  // R4
  latency_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latency_valid |-> ($past(oob_evt) && !sleep_filt));

  // R6
  nopm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sleep_filt) && !$past(link_pm)) |-> err_nopm);

  // R8
  short_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_short) |-> $past(err_clr));

  // R8
  late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_late) |-> $past(err_clr));

  // R8
  nopm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_nopm) |-> $past(err_clr));

endmodule

bind sleep_timing_monitor sleep_timing_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_raw(sleep_raw), .link_pm(link_pm),
  .oob_evt(oob_evt), .err_clr(err_clr), .sleep_filt(sleep_filt),
  .err_short(err_short), .err_late(err_late), .err_nopm(err_nopm),
  .width_valid(width_valid), .latency_valid(latency_valid)
);

// File: tb/sleep_timing_monitor_test.sv
module sleep_timing_monitor_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_raw = 1'b0, link_pm = 1'b1, oob_evt = 1'b0, err_clr = 1'b0;
  logic [15:0] db_cyc = 16'd4;
  logic [31:0] min_assert_cyc = 32'd20, max_detect_cyc = 32'd30;
  logic sleep_filt, err_short, err_late, err_nopm, width_valid, latency_valid;
  logic [31:0] assert_width, wake_latency;

  logic s_raw = 1'b0, s_oob = 1'b0;
  logic s_filt, s_es, s_el, s_en, s_wv, s_lv;
  logic [5:0] s_w, s_l;

  int checks = 0, fails = 0, wv_count = 0;

  always #5 clk = ~clk;

  sleep_timing_monitor uut (
    .clk(clk), .rst_n(rst_n), .sleep_raw(sleep_raw), .link_pm(link_pm),
    .oob_evt(oob_evt), .db_cyc(db_cyc), .min_assert_cyc(min_assert_cyc),
    .max_detect_cyc(max_detect_cyc), .err_clr(err_clr), .sleep_filt(sleep_filt),
    .err_short(err_short), .err_late(err_late), .err_nopm(err_nopm),
    .assert_width(assert_width), .width_valid(width_valid),
    .wake_latency(wake_latency), .latency_valid(latency_valid));

  sleep_timing_monitor #(.CNT_W(6), .DB_W(4)) uut_sat (
    .clk(clk), .rst_n(rst_n), .sleep_raw(s_raw), .link_pm(1'b1),
    .oob_evt(s_oob), .db_cyc(4'd2), .min_assert_cyc(6'd0),
    .max_detect_cyc(6'd63), .err_clr(1'b0), .sleep_filt(s_filt),
    .err_short(s_es), .err_late(s_el), .err_nopm(s_en),
    .assert_width(s_w), .width_valid(s_wv),
    .wake_latency(s_l), .latency_valid(s_lv));

  always @(negedge clk) if (width_valid) wv_count++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_flags();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic wait_filt_low();
    while (sleep_filt) @(negedge clk);
  endtask

  task automatic pulse_oob_after(input int k);
    repeat (k - 1) @(negedge clk);
    oob_evt = 1'b1;
    @(negedge clk);
    oob_evt = 1'b0;
  endtask

  // high, oob delay (0 = none), link_pm, short, late, nopm
  localparam int VEC [0:5][0:5] = '{
    '{40, 10, 1, 0, 0, 0},
    '{20, 30, 1, 0, 0, 0},
    '{19,  5, 1, 1, 0, 0},
    '{50,  0, 1, 0, 1, 0},
    '{30, 31, 1, 0, 1, 0},
    '{30,  3, 0, 0, 0, 1}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lat_before;
    repeat (3) @(negedge clk);
    // R8 R2 reset state
    check({err_short, err_late, err_nopm} == 3'b000, "R8 reset flags", {err_short, err_late, err_nopm}, 0);
    check(sleep_filt == 1'b0 && assert_width == 0, "R2 reset outputs", assert_width, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 debounce delay 2 + db_cyc
    sleep_raw = 1'b1;
    repeat (5) @(negedge clk);
    check(sleep_filt == 1'b0, "R1 filt before delay", sleep_filt, 0);
    @(negedge clk);
    check(sleep_filt == 1'b1, "R1 filt after delay", sleep_filt, 1);
    repeat (25) @(negedge clk);
    sleep_raw = 1'b0;
    wait_filt_low();
    pulse_oob_after(4);
    repeat (2) @(negedge clk);
    clear_flags();

    foreach (VEC[i]) begin
      clear_flags();
      link_pm = VEC[i][2][0];
      sleep_raw = 1'b1;
      repeat (VEC[i][0]) @(negedge clk);
      sleep_raw = 1'b0;
      link_pm = 1'b1;
      wait_filt_low();
      if (VEC[i][1] != 0) pulse_oob_after(VEC[i][1]);
      else repeat (40) @(negedge clk);
      repeat (2) @(negedge clk);
      check(assert_width == VEC[i][0], "R2 width", assert_width, VEC[i][0]);
      if (VEC[i][1] != 0)
        check(wake_latency == VEC[i][1], "R4 latency", wake_latency, VEC[i][1]);
      check(err_short == VEC[i][3][0], "R3 short flag", err_short, VEC[i][3]);
      check(err_late == VEC[i][4][0], "R5 late flag", err_late, VEC[i][4]);
      check(err_nopm == VEC[i][5][0], "R6 nopm flag", err_nopm, VEC[i][5]);
    end

    // R8 flag stays until cleared, then clears
    check(err_nopm == 1'b1, "R8 sticky", err_nopm, 1);
    clear_flags();
    @(negedge clk);
    check(err_nopm == 1'b0, "R8 cleared", err_nopm, 0);

    // R1 short glitch rejected
    sleep_raw = 1'b1;
    repeat (3) @(negedge clk);
    sleep_raw = 1'b0;
    repeat (12) @(negedge clk);
    check(sleep_filt == 1'b0, "R1 glitch rejected", sleep_filt, 0);

    // R1 bounced rise: one interval only
    wv_count = 0;
    repeat (2) begin
      sleep_raw = 1'b1; @(negedge clk);
      sleep_raw = 1'b0; @(negedge clk);
    end
    sleep_raw = 1'b1;
    repeat (30) @(negedge clk);
    sleep_raw = 1'b0;
    wait_filt_low();
    pulse_oob_after(2);
    repeat (2) @(negedge clk);
    check(wv_count == 1, "R1 bounce single interval", wv_count, 1);
    check(assert_width == 30, "R1 bounce width", assert_width, 30);

    // R10 stray wake event ignored
    lat_before = wake_latency;
    clear_flags();
    oob_evt = 1'b1; @(negedge clk); oob_evt = 1'b0;
    check(latency_valid == 1'b0, "R10 no valid pulse", latency_valid, 0);
    repeat (2) @(negedge clk);
    check(wake_latency == lat_before && !err_late, "R10 latency kept", wake_latency, lat_before);

    // R7 re-raise cancels pending wait
    lat_before = wake_latency;
    sleep_raw = 1'b1;
    repeat (30) @(negedge clk);
    sleep_raw = 1'b0;
    wait_filt_low();
    repeat (5) @(negedge clk);
    sleep_raw = 1'b1;
    repeat (60) @(negedge clk);
    check(err_late == 1'b0, "R7 cancel no late", err_late, 0);
    check(wake_latency == lat_before, "R7 latency kept", wake_latency, lat_before);
    sleep_raw = 1'b0;
    wait_filt_low();
    pulse_oob_after(7);
    repeat (2) @(negedge clk);
    check(wake_latency == 7, "R7 next latency", wake_latency, 7);

    // R9 saturation in narrow instance
    s_raw = 1'b1;
    repeat (100) @(negedge clk);
    s_raw = 1'b0;
    while (s_filt) @(negedge clk);
    repeat (79) @(negedge clk);
    s_oob = 1'b1; @(negedge clk); s_oob = 1'b0;
    repeat (2) @(negedge clk);
    check(s_w == 6'd63, "R9 width saturates", s_w, 63);
    check(s_l == 6'd63 && !s_el, "R9 latency saturates", s_l, 63);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule